// File: doc/BRIEF.md
# Dual-Mode Reconfigurable FIR Filter Pair

This block filters the one-bit outputs of two sigma-delta converters in a receiver that can work in a wideband mode and in a narrowband mode. It contains two identical 32-tap FIR datapaths, called A and B, and a small power detector with a gain-step controller. A single mode input does three things. It routes the bit streams into the filters. It picks the coefficient bank each filter reads, only by changing the bank base address into a computed ROM. It also decides how the front-end gain step is chosen.

In wideband mode, filter A filters stream 0 and filter B filters stream 1. Both use the same pulse-shaping coefficient set, so the outputs are the I and Q channels. In narrowband mode, only stream 0 is used and it feeds both filters. Filter A then applies a cosine-weighted bank and filter B a sine-weighted bank, both at a quarter of the sample rate. Together they turn the real low-IF stream into I and Q at baseband while also filtering the channel.

The detector adds I squared plus Q squared over windows of 256 output samples. In wideband mode it moves the gain step between two codes, with hysteresis. In narrowband mode it holds the gain step at a third, fixed code.

Top module: `dual_mode_fir_pair`

## Requirements
- R1: With `nb_mode`=0, `i_data` is computed from `sd_bit0` and `q_data` from `sd_bit1`.
- R2: With `nb_mode`=1, both filters take `sd_bit0`, and `sd_bit1` has no effect on any output.
- R3: In wideband mode both filters use the coefficients c(k)=16*w(k). Here k=0 is the newest sample, w(k)=2k+1 for k<16 and w(k)=2(31-k)+1 otherwise. An input bit 1 counts as +1 and a bit 0 counts as -1, and each output is the sum over k of c(k)*x(k).
- R4: In narrowband mode, filter A uses +8w(k) when k mod 4 = 0, -8w(k) when k mod 4 = 2, and 0 otherwise. Filter B uses +8w(k) when k mod 4 = 1, -8w(k) when k mod 4 = 3, and 0 otherwise.
- R5: An accepted sample (`in_valid`=1) gives `out_valid`=1 with the new result one clock later. This happens only once 32 samples have been accepted since the last clear. In every other cycle `out_valid`=0.
- R6: A change of `nb_mode` is seen at the next clock edge. It clears both delay lines and the power window, and the sample offered in that cycle is dropped. `out_valid` stays 0 until 32 new samples have been accepted.
- R7: While the block is in narrowband mode, `gain_step`=2.
- R8: In wideband mode, `gain_step` starts at 0 (high gain). At the end of each 256-sample window it moves from 0 to 1 if the window power is above 2^32, and from 1 to 0 if the power is below 2^28. It never changes at any other time.
- R9: After reset, `out_valid`=0, `i_data`=`q_data`=0, `gain_step`=0 and the block is in wideband mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nb_mode | input | 1 | 0 selects wideband mode, 1 selects narrowband mode |
| in_valid | input | 1 | Marks a new bit on both converter streams |
| sd_bit0 | input | 1 | Converter stream 0 |
| sd_bit1 | input | 1 | Converter stream 1 |
| out_valid | output | 1 | Strobe marking new I/Q results |
| i_data | output | 18 | Filter A result, signed |
| q_data | output | 18 | Filter B result, signed |
| gain_step | output | 2 | Front-end gain code: 0 high, 1 low, 2 narrowband |

## Verification
The assertions assume that `nb_mode` is driven by synchronous logic and held stable between clock edges. They also assume `in_valid` is a clean strobe, so a mode change and a sample may arrive in the same cycle without harm. The bench changes all inputs only on the falling edge. It switches modes while samples are still flowing, so the flushing path is exercised. It leaves gaps in `in_valid` to check that the valid strobe counts accepted samples rather than cycles. Constant-one and alternating input patterns drive the window power past each hysteresis threshold.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  // Tap weight: rises from the ends to the centre of an ntaps-long line.
  function automatic int tap_weight(input int ntaps, input int k);
    int d;
    d = 2 * k - (ntaps - 1);
    if (d < 0) d = -d;
    return ntaps - d;
  endfunction

  // Coefficient store indexed as bank*ntaps + tap.
  // Banks: 0/1 wideband shaping, 2 narrowband cosine, 3 narrowband sine.
  function automatic int coef_at(input int ntaps, input int addr);
    int bank, k, w;
    bank = addr / ntaps;
    k    = addr % ntaps;
    w    = tap_weight(ntaps, k);
    case (bank)
      0, 1: return 16 * w;
      2: return (k % 4 == 0) ? 8 * w : (k % 4 == 2) ? -8 * w : 0;
      default: return (k % 4 == 1) ? 8 * w : (k % 4 == 3) ? -8 * w : 0;
    endcase
  endfunction

  // Square of a sign-extended filter sample.
  function automatic logic [63:0] square_s(input logic signed [31:0] v);
    longint sv;
    sv = longint'(v);
    return 64'(sv * sv);
  endfunction

  typedef enum logic [1:0] {
    GAIN_HIGH = 2'd0,
    GAIN_LOW  = 2'd1,
    GAIN_NB   = 2'd2
  } gain_e;

endpackage

// File: rtl/dmf_coef_rom.sv
module dmf_coef_rom #(
  parameter int NTAPS = 32,
  parameter int CW    = 12,
  parameter int NBANK = 4,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic [BW-1:0]       bank,
  output logic [NTAPS*CW-1:0] coefs
);
  import dmf_pkg::*;

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    logic [CW-1:0] bank_val [NBANK];
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_val[b] = CW'(coef_at(NTAPS, b * NTAPS + t));
    end
    assign coefs[t*CW +: CW] = bank_val[bank];
  end

endmodule

// File: rtl/dmf_fir.sv
module dmf_fir #(
  parameter int NTAPS = 32,
  parameter int CW    = 12,
  localparam int AW   = CW + $clog2(NTAPS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 shift_en,
  input  logic                 din,
  input  logic [NTAPS*CW-1:0]  coefs,
  output logic signed [AW-1:0] acc_o
);
  logic [NTAPS-1:0]     line_q;
  logic [NTAPS-1:0]     window;
  logic signed [AW-1:0] acc_next;

  assign window = {line_q[NTAPS-2:0], din};

  always_comb begin
    acc_next = '0;
    for (int k = 0; k < NTAPS; k++) begin
      if (window[k]) acc_next = acc_next + AW'(signed'(coefs[k*CW +: CW]));
      else           acc_next = acc_next - AW'(signed'(coefs[k*CW +: CW]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      acc_o  <= '0;
    end else if (clear) begin
      line_q <= '0;
      acc_o  <= '0;
    end else if (shift_en) begin
      line_q <= window;
      acc_o  <= acc_next;
    end
  end

endmodule

// File: rtl/dmf_power_agc.sv
module dmf_power_agc #(
  parameter int          AW     = 18,
  parameter int          WIN    = 256,
  parameter int          PW     = 48,
  parameter logic [63:0] TH_UP  = 64'h1_0000_0000,
  parameter logic [63:0] TH_DN  = 64'h1000_0000,
  localparam int         WCW    = $clog2(WIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 mode_next,
  input  logic                 mode_nb,
  input  logic                 sample_valid,
  input  logic signed [AW-1:0] i_in,
  input  logic signed [AW-1:0] q_in,
  output logic [1:0]           gain,
  output logic                 win_end
);
  import dmf_pkg::*;

  logic [PW-1:0]  pacc_q;
  logic [WCW-1:0] wcnt_q;
  logic [PW-1:0]  energy;
  logic [PW-1:0]  total;
  gain_e          gain_q;
  logic [63:0]    e64;

  assign e64     = square_s(32'(i_in)) + square_s(32'(q_in));
  assign energy  = e64[PW-1:0];
  assign total   = pacc_q + energy;
  assign win_end = !flush && sample_valid && (wcnt_q == WCW'(WIN - 1));
  assign gain    = gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pacc_q <= '0;
      wcnt_q <= '0;
      gain_q <= GAIN_HIGH;
    end else if (flush) begin
      pacc_q <= '0;
      wcnt_q <= '0;
      gain_q <= mode_next ? GAIN_NB : GAIN_HIGH;
    end else if (win_end) begin
      pacc_q <= '0;
      wcnt_q <= '0;
      if (!mode_nb) begin
        if (gain_q == GAIN_HIGH && total > TH_UP[PW-1:0])      gain_q <= GAIN_LOW;
        else if (gain_q == GAIN_LOW && total < TH_DN[PW-1:0]) gain_q <= GAIN_HIGH;
      end
    end else if (sample_valid) begin
      pacc_q <= total;
      wcnt_q <= wcnt_q + 1'b1;
    end
  end

  AST_GAIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    gain != 2'd3); // R8
  AST_GAIN_ONLY_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_end && !flush) |=> $stable(gain)); // R8

endmodule

// File: rtl/dual_mode_fir_pair.sv
module dual_mode_fir_pair #(
  parameter int          NTAPS = 32,
  parameter int          CW    = 12,
  parameter int          WIN   = 256,
  parameter int          PW    = 48,
  parameter logic [63:0] TH_UP = 64'h1_0000_0000,
  parameter logic [63:0] TH_DN = 64'h1000_0000,
  localparam int         AW    = CW + $clog2(NTAPS) + 1,
  localparam int         FW    = $clog2(NTAPS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nb_mode,
  input  logic                 in_valid,
  input  logic                 sd_bit0,
  input  logic                 sd_bit1,
  output logic                 out_valid,
  output logic signed [AW-1:0] i_data,
  output logic signed [AW-1:0] q_data,
  output logic [1:0]           gain_step
);
  logic          mode_q;
  logic          flush;
  logic          accept;
  logic [FW-1:0] fill_q;
  logic          din_a, din_b;
  logic [NTAPS*CW-1:0] coefs_a, coefs_b;
  logic          win_end;

  assign flush  = (nb_mode != mode_q);
  assign accept = in_valid && !flush;
  assign din_a  = sd_bit0;
  assign din_b  = mode_q ? sd_bit0 : sd_bit1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      fill_q    <= '0;
      out_valid <= 1'b0;
    end else if (flush) begin
      mode_q    <= nb_mode;
      fill_q    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= accept && (fill_q >= FW'(NTAPS - 1));
      if (accept && fill_q < FW'(NTAPS)) fill_q <= fill_q + 1'b1;
    end
  end

  dmf_coef_rom #(.NTAPS(NTAPS), .CW(CW), .NBANK(4)) u_rom_a (
    .bank ({mode_q, 1'b0}), .coefs(coefs_a));
  dmf_coef_rom #(.NTAPS(NTAPS), .CW(CW), .NBANK(4)) u_rom_b (
    .bank ({mode_q, 1'b1}), .coefs(coefs_b));

  dmf_fir #(.NTAPS(NTAPS), .CW(CW)) u_fir_a (
    .clk(clk), .rst_n(rst_n), .clear(flush), .shift_en(accept),
    .din(din_a), .coefs(coefs_a), .acc_o(i_data));
  dmf_fir #(.NTAPS(NTAPS), .CW(CW)) u_fir_b (
    .clk(clk), .rst_n(rst_n), .clear(flush), .shift_en(accept),
    .din(din_b), .coefs(coefs_b), .acc_o(q_data));

  dmf_power_agc #(.AW(AW), .WIN(WIN), .PW(PW), .TH_UP(TH_UP), .TH_DN(TH_DN)) u_agc (
    .clk(clk), .rst_n(rst_n), .flush(flush), .mode_next(nb_mode),
    .mode_nb(mode_q), .sample_valid(out_valid), .i_in(i_data), .q_in(q_data),
    .gain(gain_step), .win_end(win_end));

  AST_VALID_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R5
  AST_FLUSH_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R6
  AST_NB_GAIN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> gain_step == 2'd2); // R7
  AST_WB_GAIN_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> gain_step != 2'd2); // R8

endmodule

// File: tb/dual_mode_fir_pair_bench.sv
module dual_mode_fir_pair_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic nb_mode = 0, in_valid = 0, sd_bit0 = 0, sd_bit1 = 0;
  logic out_valid;
  logic signed [17:0] i_data, q_data;
  logic [1:0] gain_step;

  int checks = 0, errors = 0, cycles = 0;

  dual_mode_fir_pair u_dual_mode_fir_pair (
    .clk(clk), .rst_n(rst_n), .nb_mode(nb_mode), .in_valid(in_valid),
    .sd_bit0(sd_bit0), .sd_bit1(sd_bit1), .out_valid(out_valid),
    .i_data(i_data), .q_data(q_data), .gain_step(gain_step));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  bit    ha[$], hb[$];
  bit    m_mode, m_valid;
  int    m_i, m_q, m_gain, wc;
  longint pw;

  function automatic int ref_coef(int bank, int k);
    int w;
    w = (k < 16) ? 2 * k + 1 : 2 * (31 - k) + 1;
    if (bank < 2) return 16 * w;
    if (bank == 2) case (k % 4) 0: return 8 * w; 2: return -8 * w; default: return 0; endcase
    case (k % 4) 1: return 8 * w; 3: return -8 * w; default: return 0; endcase
  endfunction

  function automatic int filt(bit h[$], int bank);
    int s = 0;
    foreach (h[k]) s += h[k] ? ref_coef(bank, k) : -ref_coef(bank, k);
    return s;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      ha.delete(); hb.delete();
      m_mode = 0; m_valid = 0; m_i = 0; m_q = 0; m_gain = 0; wc = 0; pw = 0;
    end else if (nb_mode != m_mode) begin
      m_mode = nb_mode; ha.delete(); hb.delete();
      m_valid = 0; pw = 0; wc = 0; m_gain = m_mode ? 2 : 0;
    end else begin
      if (m_valid) begin
        longint e, tot;
        e = longint'(m_i) * m_i + longint'(m_q) * m_q;
        if (wc == 255) begin
          tot = pw + e; pw = 0; wc = 0;
          if (!m_mode) begin
            if (m_gain == 0 && tot > 64'sh1_0000_0000) m_gain = 1;
            else if (m_gain == 1 && tot < 64'sh1000_0000) m_gain = 0;
          end
        end else begin
          pw += e; wc++;
        end
      end
      if (in_valid) begin
        ha.push_front(sd_bit0);
        hb.push_front(m_mode ? sd_bit0 : sd_bit1);
        if (ha.size() > 32) begin void'(ha.pop_back()); void'(hb.pop_back()); end
        m_valid = (ha.size() == 32);
        if (m_valid) begin
          m_i = filt(ha, m_mode ? 2 : 0);
          m_q = filt(hb, m_mode ? 3 : 1);
        end
      end else m_valid = 0;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(out_valid == m_valid, "R5 R6 out_valid", out_valid, m_valid);
    chk(gain_step == m_gain, m_mode ? "R7 gain_step" : "R8 gain_step", gain_step, m_gain);
    if (m_valid && out_valid) begin
      chk(i_data == m_i, m_mode ? "R2 R4 i_data" : "R1 R3 i_data", i_data, m_i);
      chk(q_data == m_q, m_mode ? "R2 R4 q_data" : "R1 R3 q_data", q_data, m_q);
    end
  endtask

  // kind: 0 random, 1 all ones, 2 alternating
  task automatic run(int n, bit mode, int kind);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      nb_mode  = mode;
      in_valid = (kind != 0) || ($urandom_range(0, 4) != 0);
      case (kind)
        1: begin sd_bit0 = 1; sd_bit1 = 1; end
        2: begin sd_bit0 = c[0]; sd_bit1 = c[0]; end
        default: begin sd_bit0 = 1'($urandom); sd_bit1 = 1'($urandom); end
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(out_valid == 0, "R9 out_valid", out_valid, 0);
    chk(i_data == 0, "R9 i_data", i_data, 0);
    chk(q_data == 0, "R9 q_data", q_data, 0);
    chk(gain_step == 0, "R9 gain_step", gain_step, 0);
    run(200, 0, 0);          // R1 R3 random wideband with gaps
    run(700, 0, 1);          // R8 strong signal
    @(negedge clk); compare();
    chk(gain_step == 1, "R8 gain lowered", gain_step, 1);
    run(700, 0, 2);          // R8 weak signal
    @(negedge clk); compare();
    chk(gain_step == 0, "R8 gain raised", gain_step, 0);
    run(400, 1, 0);          // R2 R4 R6 R7 narrowband, sd_bit1 random
    chk(gain_step == 2, "R7 narrowband gain", gain_step, 2);
    run(300, 1, 1);
    run(200, 0, 0);          // R6 back to wideband
    run(20, 1, 0);           // R6 switch before fill completes
    run(100, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule